// File: doc/BRIEF.md
# Daisy-Chain Message Forwarder

This block sits between the receive and transmit byte streams of one node in a serial daisy chain of battery monitors. It buffers incoming bytes, rebuilds framed messages, rejects damaged ones and forwards the rest downstream. Nodes carry no address. Each node knows its place from the order of the chain alone. It consumes the first byte of a balance command as its own mask. It holds back the readings-ready token until its own conversions are complete. It places its own measurement frame ahead of a read request as that request passes through.

A frame is a start byte 0xA5, a type byte, a length byte, a 16-bit check value and then 0 to 32 data bytes. The local measurement engine sees a one-cycle start pulse and answers with a done level and a 16-byte result. Bit timing of the line is handled outside this block.

Top module: `chain_fwd`

## Requirements
- R1: Incoming bytes go through a 64-entry FIFO. `rx_ready` is low exactly while 64 unread bytes are held. A byte presented with `rx_ferr` high is accepted and then thrown away.
- R2: A frame is 0xA5, type, length, check high byte, check low byte, then `length` data bytes. The check is CRC-16 with polynomial 0x1021, initial value 0xFFFF, MSB first, taken over type, length and data. A frame whose length exceeds 32 is dropped and the parser resumes its search for 0xA5.
- R3: A frame whose check value does not match is dropped. Nothing is emitted for it and no node state changes.
- R4: The FIFO may run empty while a frame is partly received. If it stays empty for GAP_CYCLES clocks, the partial frame is dropped.
- R5: A trigger frame (type 0x02) is forwarded unchanged and gives one `meas_start` pulse. If bit 0 of its first data byte is set, `bal_on` reads zero from then until the next rising edge of `meas_done`, and the stored mask returns after that edge.
- R6: A balance frame (type 0x06) with at least one data byte loads bits 5:0 of data byte 0 into `bal_on`. It is then forwarded without that byte, with its length reduced by one and a recomputed check value.
- R7: A balance frame with length 0 is not forwarded. An error frame (type 0x07, length 0) is sent in its place and `bal_on` keeps its value.
- R8: A readings-ready frame (type 0x03) is held. It is forwarded only once no measurement is pending and `meas_done` is high.
- R9: A read request (type 0x04) first makes the node send a data frame of type 0x05 and length 16. Its data bytes are `meas_data` from bits 127:120 down to bits 7:0. The request itself follows unchanged.
- R10: Frames of any other type, including awake (0x01), data (0x05), error (0x07) and unknown codes, are forwarded byte for byte.
- R11: Once `tx_valid` rises it stays high until `tx_ready` takes the byte. Every emitted frame begins with 0xA5.
- R12: After reset `tx_valid`, `meas_start` and `bal_on` are zero and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Byte from upstream receiver |
| rx_valid | input | 1 | `rx_byte` is offered |
| rx_ferr | input | 1 | Offered byte had a framing error |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_byte | output | 8 | Byte toward downstream transmitter |
| tx_valid | output | 1 | `tx_byte` is offered |
| tx_ready | input | 1 | Downstream takes the byte |
| meas_start | output | 1 | One-cycle pulse starting local measurement |
| meas_done | input | 1 | Local measurement results are ready |
| meas_data | input | 128 | Local results, six voltages then two temperatures |
| bal_on | output | 6 | Balance resistor enables, one per cell |

## Verification
The following properties are checked on every cycle: FIFO occupancy stays bounded and the stall occurs only when the FIFO is full; the outgoing valid holds under backpressure; every frame opens with the start byte; the measurement pulse lasts a single cycle and never overlaps transmission. Which frames are changed, dropped, delayed or inserted, and the check values they carry, can only be shown by the bench scenarios. Those scenarios compare whole output byte streams against frames rebuilt from the requirements. They cover stripped balance bytes, the error substitute, the held ready token and the data frame placed before a request.

// File: rtl/chain_fwd.sv
module chain_fwd #(
  parameter int          FIFO_DEPTH = 64,
  parameter int          MAX_DATA   = 32,
  parameter int          PAY_BYTES  = 16,
  parameter int          GAP_CYCLES = 64,
  parameter logic [7:0]  SOF        = 8'hA5,
  parameter logic [7:0]  T_TRIG     = 8'h02,
  parameter logic [7:0]  T_READY    = 8'h03,
  parameter logic [7:0]  T_REQ      = 8'h04,
  parameter logic [7:0]  T_DATA     = 8'h05,
  parameter logic [7:0]  T_BAL      = 8'h06,
  parameter logic [7:0]  T_ERR      = 8'h07
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             rx_byte,
  input  logic                   rx_valid,
  input  logic                   rx_ferr,
  output logic                   rx_ready,
  output logic [7:0]             tx_byte,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic                   meas_start,
  input  logic                   meas_done,
  input  logic [8*PAY_BYTES-1:0] meas_data,
  output logic [5:0]             bal_on
);

  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int BW = $clog2(MAX_DATA);
  localparam int PW = 8 * PAY_BYTES;
  localparam int GW = $clog2(GAP_CYCLES + 1);

  typedef enum logic [3:0] {HUNT, TYP, LEN, CRH, CRL, DAT, CHK, WRD, CALC, SEND} st_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  logic [7:0]    fifo_q [FIFO_DEPTH];
  logic [AW:0]   wp, rp;
  logic [7:0]    fbuf [MAX_DATA];
  st_t           st;
  logic [7:0]    f_type, f_len, idx;
  logic [15:0]   f_crc, crc_acc;
  logic [7:0]    t_type, t_len;
  logic [15:0]   t_crc;
  logic          t_off, t_src, follow;
  logic [5:0]    bal_q;
  logic          inhibit, busy, done_q;
  logic [GW-1:0] gap_q;

  wire empty = (wp == rp);
  wire full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  wire push  = rx_valid && !full && !rx_ferr;
  wire in_rx = st inside {TYP, LEN, CRH, CRL, DAT};
  wire pop   = !empty && (in_rx || st == HUNT);
  wire [7:0] head = fifo_q[rp[AW-1:0]];

  assign rx_ready = !full;
  assign tx_valid = (st == SEND);
  assign bal_on   = (busy && inhibit) ? 6'd0 : bal_q;

  logic [7:0]    jx, bj, dbyte, cbyte;
  logic [PW-1:0] pshift;

  always_comb begin
    jx     = (st == CALC) ? idx - 8'd2 : idx - 8'd5;
    bj     = jx + {7'd0, t_off};
    pshift = meas_data << (8 * jx);
    dbyte  = t_src ? pshift[PW-1 -: 8] : fbuf[bj[BW-1:0]];
    cbyte  = (idx == 8'd0) ? t_type : (idx == 8'd1) ? t_len : dbyte;
    case (idx)
      8'd0:    tx_byte = SOF;
      8'd1:    tx_byte = t_type;
      8'd2:    tx_byte = t_len;
      8'd3:    tx_byte = t_crc[15:8];
      8'd4:    tx_byte = t_crc[7:0];
      default: tx_byte = dbyte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) fifo_q[wp[AW-1:0]] <= rx_byte;
    if (st == DAT && pop) fbuf[idx[BW-1:0]] <= head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0;
      st <= HUNT;
      f_type <= '0; f_len <= '0; f_crc <= '0; crc_acc <= '0; idx <= '0;
      t_type <= '0; t_len <= '0; t_crc <= '0; t_off <= 1'b0; t_src <= 1'b0; follow <= 1'b0;
      bal_q <= '0; inhibit <= 1'b0; busy <= 1'b0; done_q <= 1'b0;
      meas_start <= 1'b0; gap_q <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      meas_start <= 1'b0;
      done_q <= meas_done;
      if (meas_done && !done_q) busy <= 1'b0;

      case (st)
        HUNT: if (pop && head == SOF) st <= TYP;
        TYP: if (pop) begin
          f_type  <= head;
          crc_acc <= crc_step(16'hFFFF, head);
          st      <= LEN;
        end
        LEN: if (pop) begin
          f_len   <= head;
          crc_acc <= crc_step(crc_acc, head);
          st      <= (head > 8'(MAX_DATA)) ? HUNT : CRH;
        end
        CRH: if (pop) begin
          f_crc[15:8] <= head;
          st          <= CRL;
        end
        CRL: if (pop) begin
          f_crc[7:0] <= head;
          idx        <= '0;
          st         <= (f_len == 8'd0) ? CHK : DAT;
        end
        DAT: if (pop) begin
          crc_acc <= crc_step(crc_acc, head);
          idx     <= idx + 8'd1;
          if (idx == f_len - 8'd1) st <= CHK;
        end
        CHK: begin
          idx    <= '0;
          t_crc  <= 16'hFFFF;
          t_type <= f_type;
          t_len  <= f_len;
          t_off  <= 1'b0;
          t_src  <= 1'b0;
          follow <= 1'b0;
          st     <= CALC;
          if (crc_acc != f_crc) st <= HUNT;
          else if (f_type == T_BAL) begin
            if (f_len == 8'd0) t_type <= T_ERR;
            else begin
              bal_q <= fbuf[0][5:0];
              t_len <= f_len - 8'd1;
              t_off <= 1'b1;
            end
          end else if (f_type == T_TRIG) begin
            meas_start <= 1'b1;
            busy       <= 1'b1;
            inhibit    <= (f_len != 8'd0) && fbuf[0][0];
          end else if (f_type == T_READY) begin
            st <= WRD;
          end else if (f_type == T_REQ) begin
            t_type <= T_DATA;
            t_len  <= 8'(PAY_BYTES);
            t_src  <= 1'b1;
            follow <= 1'b1;
          end
        end
        WRD: if (!busy && meas_done) st <= CALC;
        CALC: begin
          t_crc <= crc_step(t_crc, cbyte);
          idx   <= idx + 8'd1;
          if (idx == t_len + 8'd1) begin
            idx <= '0;
            st  <= SEND;
          end
        end
        SEND: if (tx_ready) begin
          idx <= idx + 8'd1;
          if (idx == t_len + 8'd4) begin
            idx <= '0;
            if (follow) begin
              follow <= 1'b0;
              t_type <= f_type;
              t_len  <= f_len;
              t_src  <= 1'b0;
              t_crc  <= 16'hFFFF;
              st     <= CALC;
            end else begin
              st <= HUNT;
            end
          end
        end
        default: st <= HUNT;
      endcase

      if (pop) gap_q <= '0;
      else if (in_rx) begin
        gap_q <= gap_q + 1'b1;
        if (gap_q == GW'(GAP_CYCLES - 1)) begin
          gap_q <= '0;
          st    <= HUNT;
        end
      end
    end
  end

endmodule

// File: rtl/chain_fwd_chk.sv
module chain_fwd_chk #(
  parameter int         FD  = 64,
  parameter logic [7:0] SOF = 8'hA5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_ready,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [7:0]           tx_byte,
  input logic                 meas_start,
  input logic [$clog2(FD):0]  fill
);

  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= FD);

  a_r1_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> int'(fill) == FD);

  a_r11_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid);

  a_r11_sof_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_byte == SOF);

  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |=> !meas_start);

  a_r5_start_not_sending: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |-> !tx_valid);

endmodule

bind chain_fwd chain_fwd_chk #(.FD(FIFO_DEPTH), .SOF(SOF)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_byte(tx_byte), .meas_start(meas_start), .fill(wp - rp)
);

// File: tb/test_chain_fwd.sv
`timescale 1ns/1ps
module test_chain_fwd;

  localparam int GAP = 64;
  localparam logic [7:0] SOF = 8'hA5;

  typedef struct packed {
    logic [7:0]  ty;
    logic [7:0]  ln;
    logic [23:0] d;
    logic [7:0]  ety;
    logic [7:0]  eln;
    logic [7:0]  eoff;
    logic [7:0]  ebal;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h01, 8'd0, 24'h000000, 8'h01, 8'd0, 8'd0, 8'h00, 8'd10}, // R10 awake
    '{8'h05, 8'd3, 24'h112233, 8'h05, 8'd3, 8'd0, 8'h00, 8'd10}, // R10 data
    '{8'h06, 8'd3, 24'h2A4455, 8'h06, 8'd2, 8'd1, 8'h2A, 8'd6},  // R6 strip
    '{8'h06, 8'd1, 24'hFF0000, 8'h06, 8'd0, 8'd1, 8'h3F, 8'd6},  // R6 last byte
    '{8'h06, 8'd0, 24'h000000, 8'h07, 8'd0, 8'd0, 8'h3F, 8'd7},  // R7 empty
    '{8'h07, 8'd2, 24'h010200, 8'h07, 8'd2, 8'd0, 8'h3F, 8'd10}, // R10 error
    '{8'h33, 8'd1, 24'hC30000, 8'h33, 8'd1, 8'd0, 8'h3F, 8'd10}, // R10 unknown
    '{8'h02, 8'd1, 24'h000000, 8'h02, 8'd1, 8'd0, 8'h3F, 8'd5}   // R5 trigger
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [7:0]   rx_byte = 8'h00;
  logic         rx_valid = 1'b0, rx_ferr = 1'b0;
  logic         rx_ready;
  logic [7:0]   tx_byte;
  logic         tx_valid;
  logic         tx_ready = 1'b1;
  logic         meas_start;
  logic         meas_done = 1'b0;
  logic [127:0] meas_data = '0;
  logic [5:0]   bal_on;

  chain_fwd #(.GAP_CYCLES(GAP)) i_chain_fwd (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
    .rx_ready(rx_ready), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .meas_start(meas_start), .meas_done(meas_done), .meas_data(meas_data), .bal_on(bal_on)
  );

  int n_chk = 0, n_bad = 0, base = 0, exp_n = 0, cap_n = 0, starts = 0;
  bit bp = 1'b0, hold = 1'b0, finished = 1'b0;
  logic [7:0] cap  [0:2047];
  logic [7:0] expb [0:255];
  logic [7:0] pd   [0:31];
  logic [7:0] md   [0:15];

  always @(negedge clk) begin
    if (tx_valid && tx_ready && cap_n < 2048) begin
      cap[cap_n] = tx_byte;
      cap_n++;
    end
    if (meas_start) starts++;
  end

  always @(posedge clk) begin
    #1;
    tx_ready = hold ? 1'b0 : (bp ? ~tx_ready : 1'b1);
  end

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic put(input logic [7:0] b, input logic fe);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_byte = b; rx_ferr = fe; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] ty, input int ln, input logic bad, input int junk_at);
    logic [15:0] c;
    c = crc_upd(16'hFFFF, ty);
    c = crc_upd(c, 8'(ln));
    for (int i = 0; i < ln; i++) c = crc_upd(c, pd[i]);
    if (bad) c = c ^ 16'h0001;
    put(SOF, 1'b0); put(ty, 1'b0); put(8'(ln), 1'b0); put(c[15:8], 1'b0); put(c[7:0], 1'b0);
    for (int i = 0; i < ln; i++) begin
      if (i == junk_at) put(8'h5A, 1'b1);
      put(pd[i], 1'b0);
    end
  endtask

  task automatic add_exp(input logic [7:0] ty, input int ln, input int off, input logic from_md);
    logic [15:0] c;
    logic [7:0]  b;
    c = crc_upd(16'hFFFF, ty);
    c = crc_upd(c, 8'(ln));
    for (int i = 0; i < ln; i++) begin
      b = from_md ? md[i] : pd[i + off];
      c = crc_upd(c, b);
    end
    expb[exp_n] = SOF; expb[exp_n+1] = ty; expb[exp_n+2] = 8'(ln);
    expb[exp_n+3] = c[15:8]; expb[exp_n+4] = c[7:0];
    exp_n += 5;
    for (int i = 0; i < ln; i++) begin
      expb[exp_n] = from_md ? md[i] : pd[i + off];
      exp_n++;
    end
  endtask

  task automatic expect_out(input string tag);
    int got;
    repeat (300) @(negedge clk);
    n_chk++;
    got = cap_n - base;
    if (got != exp_n) begin
      n_bad++;
      $display("FAIL %s: %0d bytes emitted, expected %0d", tag, got, exp_n);
    end else begin
      for (int i = 0; i < exp_n; i++) begin
        if (cap[base + i] !== expb[i]) begin
          n_bad++;
          $display("FAIL %s: byte %0d is %02h, expected %02h", tag, i, cap[base + i], expb[i]);
          break;
        end
      end
    end
    base = cap_n;
    exp_n = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %0h, expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    int s0, acc;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 tx_valid", 32'(tx_valid), 0);
    chk("R12 meas_start", 32'(meas_start), 0);
    chk("R12 bal_on", 32'(bal_on), 0);
    chk("R12 rx_ready", 32'(rx_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    base = cap_n;

    s0 = starts;
    for (int v = 0; v < 8; v++) begin
      pd[0] = VECS[v].d[23:16]; pd[1] = VECS[v].d[15:8]; pd[2] = VECS[v].d[7:0];
      send_frame(VECS[v].ty, int'(VECS[v].ln), 1'b0, -1);
      add_exp(VECS[v].ety, int'(VECS[v].eln), int'(VECS[v].eoff), 1'b0);
      expect_out($sformatf("R%0d vector %0d frame", VECS[v].req, v));
      chk($sformatf("R%0d vector %0d bal_on", VECS[v].req, v), 32'(bal_on), 32'(VECS[v].ebal[5:0]));
    end
    chk("R5 one start pulse", 32'(starts - s0), 1);

    // R3 bad check value: no output, mask unchanged
    pd[0] = 8'h01;
    send_frame(8'h06, 1, 1'b1, -1);
    expect_out("R3 bad crc dropped");
    chk("R3 bal_on kept", 32'(bal_on), 32'h3F);

    // R2 length above 32 dropped, next frame still parsed
    put(SOF, 1'b0); put(8'h01, 1'b0); put(8'h21, 1'b0);
    send_frame(8'h01, 0, 1'b0, -1);
    add_exp(8'h01, 0, 0, 1'b0);
    expect_out("R2 overlength dropped");

    // R1 framing-error byte thrown away
    pd[0] = 8'hAA; pd[1] = 8'hBB;
    send_frame(8'h05, 2, 1'b0, 1);
    add_exp(8'h05, 2, 0, 1'b0);
    expect_out("R1 ferr byte dropped");

    // R4 gap timeout drops partial frame
    put(SOF, 1'b0); put(8'h01, 1'b0); put(8'h00, 1'b0);
    repeat (GAP + 20) @(negedge clk);
    send_frame(8'h01, 0, 1'b0, -1);
    add_exp(8'h01, 0, 0, 1'b0);
    expect_out("R4 gap discard");

    // R5 trigger with balance-off flag
    s0 = starts;
    pd[0] = 8'h01;
    send_frame(8'h02, 1, 1'b0, -1);
    add_exp(8'h02, 1, 0, 1'b0);
    expect_out("R5 trigger forwarded");
    chk("R5 pulse", 32'(starts - s0), 1);
    chk("R5 balance off", 32'(bal_on), 0);

    // R8 ready held until done
    send_frame(8'h03, 0, 1'b0, -1);
    expect_out("R8 ready held");
    @(negedge clk); meas_done = 1'b1;
    add_exp(8'h03, 0, 0, 1'b0);
    expect_out("R8 ready released");
    chk("R5 balance restored", 32'(bal_on), 32'h3F);
    meas_done = 1'b0;

    // R9 local data before request
    for (int i = 0; i < 16; i++) begin
      md[i] = 8'(16 * i + 3);
      meas_data[8*(15-i) +: 8] = md[i];
    end
    send_frame(8'h04, 0, 1'b0, -1);
    add_exp(8'h05, 16, 0, 1'b1);
    add_exp(8'h04, 0, 0, 1'b0);
    expect_out("R9 data then request");

    // R11 backpressure
    bp = 1'b1;
    pd[0] = 8'h9C; pd[1] = 8'h6E;
    send_frame(8'h05, 2, 1'b0, -1);
    add_exp(8'h05, 2, 0, 1'b0);
    expect_out("R11 stalled output");
    bp = 1'b0;

    // R1 FIFO fills to 64 while output is stalled
    hold = 1'b1;
    send_frame(8'h01, 0, 1'b0, -1);
    acc = 0;
    @(negedge clk);
    rx_byte = 8'h00; rx_valid = 1'b1;
    for (int k = 0; k < 80; k++) begin
      if (rx_ready) acc++;
      @(negedge clk);
    end
    rx_valid = 1'b0;
    chk("R1 fifo accepts 64", 32'(acc), 64);
    chk("R1 rx_ready low when full", 32'(rx_ready), 0);
    hold = 1'b0;
    add_exp(8'h01, 0, 0, 1'b0);
    expect_out("R1 frame after full fifo");
    chk("R1 rx_ready after drain", 32'(rx_ready), 1);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run incomplete, expected finish");
      summary();
      $finish;
    end
  end

endmodule